// File: doc/BRIEF.md
# OFDM Cyclic Prefix and Preamble Framer

This block sits at the end of an OFDM transmit chain. It takes time-domain symbol blocks of 64 complex samples from an upstream transform stage and turns them into one continuous sample stream. Every frame opens with a 320-sample training preamble read from a loadable table. Each data symbol that follows goes out as 80 samples: a 16-sample cyclic prefix that repeats the symbol's own tail, then the full 64-sample symbol.

The whole block runs on one fabric clock that is four times the highest sample rate. Output samples are qualified by a valid strobe that fires every 4, 8 or 16 clocks. The period is chosen per frame. Two symbol buffers work as a ping-pong pair, so the next block can load while the current one plays out. A frame ends cleanly after a symbol flagged as last. If the next symbol is not ready when it is needed, the frame is aborted and an underrun is flagged, so stale data is never sent.

Top module: `ofdm_cp_framer`

## Requirements
- R1: After reset `out_valid`, `out_end`, `underrun` and `busy` are 0 and `in_ready` is 1.
- R2: While a frame is active, `out_valid` pulses once every P clocks. P is 4, 8 or 16 for `rate_sel` = 0, 1 or 2, and a value of 3 also gives 16. The first pulse comes P clocks after the clock edge at which `start` is accepted.
- R3: The first 320 valid samples of a frame are preamble table entries 0, 1, ... 319 in order. `out_pre` is 1 on each of them and 0 on all other samples. A sample is packed as {I, Q}.
- R4: Each data symbol produces 80 valid samples, taken from block indices 48..63 and then 0..63. Index k is the (k+1)-th accepted input sample of the block.
- R5: A block is made of 64 accepted transfers (`in_valid` and `in_ready` both 1 at a clock edge). `in_ready` is 0 exactly while two complete blocks are held. A block's storage is freed at the edge that emits its 80th sample, and blocks are played in arrival order.
- R6: If `in_last` is 1 on a block's 64th transfer, that block ends the frame. `out_end` is 1 with its 80th sample, and `busy` is 0 from the same cycle.
- R7: If the next complete block is not held when the preamble's last sample or a non-last symbol's 80th sample is emitted, `underrun` is 1 with that sample. `busy` drops in the same cycle and no further sample follows.
- R8: `start` has no effect while `busy` is 1.
- R9: A table write (`tbl_we` = 1) stores {`tbl_i`, `tbl_q`} at entry `tbl_addr`. A frame started after the write uses the new value.
- R10: `rate_sel` is sampled only when a frame starts. Changing it during a frame leaves the strobe period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Strobe period select, sampled at frame start |
| start | input | 1 | Frame start pulse |
| tbl_we | input | 1 | Preamble table write enable |
| tbl_addr | input | 9 | Preamble table entry index |
| tbl_i | input | 16 | Preamble entry, in-phase part |
| tbl_q | input | 16 | Preamble entry, quadrature part |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample can be accepted |
| in_i | input | 16 | Input sample, in-phase part |
| in_q | input | 16 | Input sample, quadrature part |
| in_last | input | 1 | On a block's final transfer: block ends the frame |
| busy | output | 1 | Frame in progress |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Output sample, in-phase part |
| out_q | output | 16 | Output sample, quadrature part |
| out_pre | output | 1 | Current sample belongs to the preamble |
| out_end | output | 1 | Final sample of a completed frame |
| underrun | output | 1 | Frame aborted for lack of a symbol |

## Verification
The hardest case to reach is a block that finishes loading in the very clock where the previous symbol's 80th sample leaves. It also takes a full buffer pair pushing back on the input while a frame is already playing. The bench reaches both by preloading two blocks before `start` and then streaming further blocks as fast as `in_ready` allows. It uses every rate so the strobe phase lands at different offsets against the input. Separate frames starve the sequencer on purpose, once right after the preamble and once after a non-last symbol, and the cycle model checks exactly where `underrun` rises.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PRE  = 2'd1,
      SEQ_CP   = 2'd2,
      SEQ_BODY = 2'd3
   } cpf_seq_e;

   function automatic int cpf_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cpf_rate_strobe.sv
module cpf_rate_strobe #(
   parameter int BASE_DIV  = 4,
   parameter int NUM_RATES = 3,
   parameter int RSEL_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic [RSEL_W-1:0] rate_sel,
   output logic              strobe
);
   localparam int MAXP = BASE_DIV << (NUM_RATES - 1);
   localparam int CW   = $clog2(MAXP) + 1;

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("cpf_rate_strobe: BASE_DIV must be at least 2");
      end
      if (NUM_RATES > (1 << RSEL_W)) begin : g_bad_sel
         $error("cpf_rate_strobe: RSEL_W too narrow for NUM_RATES");
      end
   endgenerate

   logic [CW-1:0]     per_q, cnt_q, per_d;
   logic [RSEL_W-1:0] sel_c;

   always_comb begin
      sel_c = (int'(rate_sel) >= NUM_RATES) ? RSEL_W'(NUM_RATES - 1) : rate_sel;
      per_d = CW'(BASE_DIV) << sel_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= CW'(BASE_DIV);
         cnt_q <= '0;
      end else if (restart) begin
         per_q <= per_d;
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= (cnt_q == per_q - CW'(1)) ? '0 : cnt_q + CW'(1);
      end
   end

   assign strobe = run && (cnt_q == per_q - CW'(1));

   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe) else $error("strobe twice in a row"); // R2
   AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart) |=> $stable(per_q)) else $error("period changed mid-frame"); // R10
endmodule

// File: rtl/cpf_pre_table.sv
module cpf_pre_table #(
   parameter int DEPTH = 320,
   parameter int SW    = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [SW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [SW-1:0]            rdata
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("cpf_pre_table: DEPTH must be positive");
      end
   endgenerate

   logic [SW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
   end

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign rdata = mem[raddr];
      end else begin : g_guard
         assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
      end
   endgenerate
endmodule

// File: rtl/cpf_sym_bank.sv
module cpf_sym_bank #(
   parameter int SW      = 32,
   parameter int SYM_LEN = 64,
   parameter int NBUF    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_valid,
   output logic                       wr_ready,
   input  logic [SW-1:0]              wr_data,
   input  logic                       wr_last,
   input  logic [$clog2(SYM_LEN)-1:0] rd_idx,
   output logic [SW-1:0]              rd_data,
   output logic                       head_full,
   output logic                       head_last,
   output logic                       next_full,
   input  logic                       pop
);
   localparam int IW = $clog2(SYM_LEN);
   localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1;

   generate
      if (NBUF < 2) begin : g_bad_nbuf
         $error("cpf_sym_bank: at least two buffers are needed");
      end
   endgenerate

   function automatic logic [BW-1:0] adv(input logic [BW-1:0] s);
      return (int'(s) == NBUF - 1) ? '0 : s + BW'(1);
   endfunction

   logic [NBUF-1:0] full_q, last_q;
   logic [BW-1:0]   wsel_q, rsel_q;
   logic [IW-1:0]   wptr_q;
   logic [SW-1:0]   bank_q [NBUF];
   logic            wr_fire, blk_done;

   assign wr_ready = !full_q[wsel_q];
   assign wr_fire  = wr_valid && wr_ready;
   assign blk_done = wr_fire && (wptr_q == IW'(SYM_LEN - 1));

   genvar b;
   generate
      for (b = 0; b < NBUF; b++) begin : g_buf
         logic [SW-1:0] mem [SYM_LEN];
         always_ff @(posedge clk) begin
            if (wr_fire && (wsel_q == BW'(b))) mem[wptr_q] <= wr_data;
         end
         assign bank_q[b] = mem[rd_idx];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= '0;
         last_q <= '0;
         wsel_q <= '0;
         rsel_q <= '0;
         wptr_q <= '0;
      end else begin
         if (wr_fire) wptr_q <= blk_done ? '0 : wptr_q + IW'(1);
         if (blk_done) wsel_q <= adv(wsel_q);
         if (pop) rsel_q <= adv(rsel_q);
         for (int i = 0; i < NBUF; i++) begin
            if (blk_done && (wsel_q == BW'(i))) begin
               full_q[i] <= 1'b1;
               last_q[i] <= wr_last;
            end else if (pop && (rsel_q == BW'(i))) begin
               full_q[i] <= 1'b0;
            end
         end
      end
   end

   assign rd_data   = bank_q[rsel_q];
   assign head_full = full_q[rsel_q];
   assign head_last = last_q[rsel_q];
   assign next_full = full_q[adv(rsel_q)];

   AST_POP_HEAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_full) else $error("pop of empty buffer"); // R4
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> $stable(wptr_q)) else $error("write advanced while stalled"); // R5
   AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !blk_done) |=> (rsel_q != $past(rsel_q))) else $error("read pointer stuck"); // R5
endmodule

// File: rtl/ofdm_cp_framer.sv
module ofdm_cp_framer #(
   parameter int DW        = 16,
   parameter int SYM_LEN   = 64,
   parameter int CP_LEN    = 16,
   parameter int PRE_LEN   = 320,
   parameter int NBUF      = 2,
   parameter int BASE_DIV  = 4,
   parameter int NUM_RATES = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 rate_sel,
   input  logic                       start,
   input  logic                       tbl_we,
   input  logic [$clog2(PRE_LEN)-1:0] tbl_addr,
   input  logic [DW-1:0]              tbl_i,
   input  logic [DW-1:0]              tbl_q,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [DW-1:0]              in_i,
   input  logic [DW-1:0]              in_q,
   input  logic                       in_last,
   output logic                       busy,
   output logic                       out_valid,
   output logic [DW-1:0]              out_i,
   output logic [DW-1:0]              out_q,
   output logic                       out_pre,
   output logic                       out_end,
   output logic                       underrun
);
   import cpf_pkg::*;

   localparam int SW     = 2 * DW;
   localparam int AW     = $clog2(PRE_LEN);
   localparam int IW     = $clog2(SYM_LEN);
   localparam int PW     = $clog2(cpf_max(PRE_LEN, SYM_LEN));
   localparam int CP_OFF = SYM_LEN - CP_LEN;

   generate
      if (CP_LEN < 1 || CP_LEN > SYM_LEN) begin : g_bad_cp
         $error("ofdm_cp_framer: CP_LEN must lie in 1..SYM_LEN");
      end
      if (PW < AW || PW < IW) begin : g_bad_pw
         $error("ofdm_cp_framer: position counter too narrow");
      end
   endgenerate

   cpf_seq_e      seq_q;
   logic [PW-1:0] pos_q;
   logic          stb, go, pop;
   logic [SW-1:0] tbl_rd, sym_rd;
   logic [IW-1:0] sym_idx;
   logic          head_full, head_last, next_full;

   assign busy = (seq_q != SEQ_IDLE);
   assign go   = start && !busy;

   cpf_rate_strobe #(
      .BASE_DIV (BASE_DIV),
      .NUM_RATES(NUM_RATES),
      .RSEL_W   (2)
   ) i_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (go),
      .run     (busy),
      .rate_sel(rate_sel),
      .strobe  (stb)
   );

   cpf_pre_table #(
      .DEPTH(PRE_LEN),
      .SW   (SW)
   ) i_table (
      .clk  (clk),
      .we   (tbl_we),
      .waddr(tbl_addr),
      .wdata({tbl_i, tbl_q}),
      .raddr(pos_q[AW-1:0]),
      .rdata(tbl_rd)
   );

   assign sym_idx = (seq_q == SEQ_CP) ? (IW'(CP_OFF) + pos_q[IW-1:0]) : pos_q[IW-1:0];
   assign pop     = stb && (seq_q == SEQ_BODY) && (pos_q == PW'(SYM_LEN - 1));

   cpf_sym_bank #(
      .SW     (SW),
      .SYM_LEN(SYM_LEN),
      .NBUF   (NBUF)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid),
      .wr_ready (in_ready),
      .wr_data  ({in_i, in_q}),
      .wr_last  (in_last),
      .rd_idx   (sym_idx),
      .rd_data  (sym_rd),
      .head_full(head_full),
      .head_last(head_last),
      .next_full(next_full),
      .pop      (pop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q     <= SEQ_IDLE;
         pos_q     <= '0;
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         out_pre   <= 1'b0;
         out_end   <= 1'b0;
         underrun  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_pre   <= 1'b0;
         out_end   <= 1'b0;
         underrun  <= 1'b0;
         if (go) begin
            seq_q <= SEQ_PRE;
            pos_q <= '0;
         end else if (stb) begin
            out_valid <= 1'b1;
            unique case (seq_q)
               SEQ_PRE: begin
                  {out_i, out_q} <= tbl_rd;
                  out_pre        <= 1'b1;
                  if (pos_q == PW'(PRE_LEN - 1)) begin
                     pos_q <= '0;
                     if (head_full) begin
                        seq_q <= SEQ_CP;
                     end else begin
                        seq_q    <= SEQ_IDLE;
                        underrun <= 1'b1;
                     end
                  end else begin
                     pos_q <= pos_q + PW'(1);
                  end
               end
               SEQ_CP: begin
                  {out_i, out_q} <= sym_rd;
                  if (pos_q == PW'(CP_LEN - 1)) begin
                     pos_q <= '0;
                     seq_q <= SEQ_BODY;
                  end else begin
                     pos_q <= pos_q + PW'(1);
                  end
               end
               SEQ_BODY: begin
                  {out_i, out_q} <= sym_rd;
                  if (pos_q == PW'(SYM_LEN - 1)) begin
                     pos_q <= '0;
                     if (head_last) begin
                        seq_q   <= SEQ_IDLE;
                        out_end <= 1'b1;
                     end else if (next_full) begin
                        seq_q <= SEQ_CP;
                     end else begin
                        seq_q    <= SEQ_IDLE;
                        underrun <= 1'b1;
                     end
                  end else begin
                     pos_q <= pos_q + PW'(1);
                  end
               end
               default: seq_q <= SEQ_IDLE;
            endcase
         end
      end
   end

   AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (!busy && out_valid)) else $error("underrun without abort"); // R7
   AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_end |-> (!busy && !underrun)) else $error("frame end while busy"); // R6
   AST_HEAD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q == SEQ_CP || seq_q == SEQ_BODY) |-> head_full) else $error("symbol playing from empty buffer"); // R4
   AST_PRE_FLAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_pre |-> out_valid) else $error("preamble flag without sample"); // R3
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && seq_q != SEQ_PRE) |=> (seq_q != SEQ_PRE)) else $error("restart while busy"); // R8
endmodule

// File: tb/test_ofdm_cp_framer.sv
module test_ofdm_cp_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rate_sel = 2'd0;
   logic        start = 1'b0;
   logic        tbl_we = 1'b0;
   logic [8:0]  tbl_addr = '0;
   logic [15:0] tbl_i = '0, tbl_q = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_i = '0, in_q = '0;
   logic        in_last = 1'b0;
   logic        busy, out_valid, out_pre, out_end, underrun;
   logic [15:0] out_i, out_q;

   always #2 clk = ~clk;

   ofdm_cp_framer i_ofdm_cp_framer (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start(start),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_i(tbl_i), .tbl_q(tbl_q),
      .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
      .in_last(in_last), .busy(busy), .out_valid(out_valid), .out_i(out_i),
      .out_q(out_q), .out_pre(out_pre), .out_end(out_end), .underrun(underrun)
   );

   int checks = 0, errors = 0;
   bit chk_en = 1'b0;
   int pre_cnt = 0, und_cnt = 0, end_cnt = 0;

   // behavioural reference model
   bit          m_act;
   int          m_pos, m_div, m_per;
   logic [31:0] sq[$];
   bit          lq[$];
   logic [31:0] part[$];
   logic [31:0] pre_m [320];
   bit          e_valid, e_pre, e_end, e_und;
   logic [31:0] e_data;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int nsym;
      int j;
      bit lf;
      if (!rst_n) begin
         m_act = 0; m_pos = 0; m_div = 0; m_per = 4;
         sq.delete(); lq.delete(); part.delete();
         e_valid = 0; e_pre = 0; e_end = 0; e_und = 0; e_data = '0;
      end else begin
         nsym = lq.size();
         e_valid = 0; e_pre = 0; e_end = 0; e_und = 0;
         if (!m_act) begin
            if (start) begin
               m_act = 1; m_pos = 0; m_div = 0;
               m_per = (rate_sel == 2'd0) ? 4 : (rate_sel == 2'd1) ? 8 : 16;
            end
         end else if (m_div == m_per - 1) begin
            m_div = 0;
            e_valid = 1;
            if (m_pos < 320) begin
               e_data = pre_m[m_pos];
               e_pre = 1;
               if (m_pos == 319 && nsym < 1) begin
                  e_und = 1; m_act = 0;
               end
               m_pos++;
            end else begin
               j = (m_pos - 320) % 80;
               e_data = sq[(j < 16) ? 48 + j : j - 16];
               if (j == 79) begin
                  lf = lq[0];
                  repeat (64) void'(sq.pop_front());
                  void'(lq.pop_front());
                  m_pos = 320;
                  if (lf) begin
                     e_end = 1; m_act = 0;
                  end else if (nsym < 2) begin
                     e_und = 1; m_act = 0;
                  end
               end else begin
                  m_pos++;
               end
            end
         end else begin
            m_div++;
         end
         if (tbl_we && tbl_addr < 9'd320) pre_m[tbl_addr] = {tbl_i, tbl_q};
         if (in_valid && nsym < 2) begin
            part.push_back({in_i, in_q});
            if (part.size() == 64) begin
               foreach (part[k]) sq.push_back(part[k]);
               lq.push_back(in_last);
               part.delete();
            end
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         check(out_valid === e_valid, "R2 R10 out_valid", 32'(out_valid), 32'(e_valid));
         if (e_valid)
            check({out_i, out_q} === e_data, e_pre ? "R3 R9 preamble data" : "R4 symbol data",
                  {out_i, out_q}, e_data);
         check(out_pre === e_pre, "R3 out_pre", 32'(out_pre), 32'(e_pre));
         check(out_end === e_end, "R6 out_end", 32'(out_end), 32'(e_end));
         check(underrun === e_und, "R7 underrun", 32'(underrun), 32'(e_und));
         check(in_ready === (lq.size() < 2), "R5 in_ready", 32'(in_ready), 32'(lq.size() < 2));
         check(busy === m_act, "R8 busy", 32'(busy), 32'(m_act));
         if (out_valid && out_pre) pre_cnt++;
         if (underrun) und_cnt++;
         if (out_end) end_cnt++;
      end
   end

   function automatic logic [31:0] symv(input int f, input int s, input int i);
      return {16'(f * 4096 + s * 256 + i), 16'(16'hA000 ^ (i * 37) ^ (s << 9) ^ f)};
   endfunction

   function automatic logic [31:0] prev(input int a, input int g);
      return {16'(a * 5 + g * 7777), 16'(~a ^ (g << 12))};
   endfunction

   task automatic tbl_write(input int a, input logic [31:0] v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 9'(a); {tbl_i, tbl_q} = v;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic push(input logic [31:0] v, input bit lst);
      @(negedge clk);
      in_valid = 1'b1; {in_i, in_q} = v; in_last = lst;
      while (!in_ready) @(negedge clk);
   endtask

   task automatic push_sym(input int f, input int s, input bit lst);
      for (int i = 0; i < 64; i++) push(symv(f, s, i), lst && (i == 63));
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic pulse_start(input logic [1:0] r);
      @(negedge clk);
      rate_sel = r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
      check(busy === 1'b0, "R1 busy", 32'(busy), 0);
      check(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
      check(underrun === 1'b0 && out_end === 1'b0, "R1 flags", {out_end, underrun}, 0);
      chk_en = 1'b1;

      for (int a = 0; a < 320; a++) tbl_write(a, prev(a, 0));

      // Frame A: fastest rate, two blocks preloaded, two streamed (R5 back-pressure)
      push_sym(1, 0, 0);
      push_sym(1, 1, 0);
      pulse_start(2'd0);
      push_sym(1, 2, 0);
      push_sym(1, 3, 1);
      wait_idle();
      check(end_cnt == 1 && und_cnt == 0, "R6 frame A end", 32'(end_cnt), 1);

      // Frame B: rate 8, extra start pulse and rate change mid-frame (R8, R10)
      pre_cnt = 0;
      push_sym(2, 0, 0);
      fork
         begin
            pulse_start(2'd1);
            repeat (600) @(negedge clk);
            pulse_start(2'd0);
         end
         begin
            push_sym(2, 1, 0);
            push_sym(2, 2, 1);
         end
      join
      wait_idle();
      check(pre_cnt == 320, "R8 single preamble", 32'(pre_cnt), 320);
      check(end_cnt == 2, "R6 frame B end", 32'(end_cnt), 2);

      // Frame C: no symbol at all -> underrun after preamble (R7)
      pulse_start(2'd0);
      wait_idle();
      check(und_cnt == 1, "R7 underrun after preamble", 32'(und_cnt), 1);

      // Frame D: new table head (R9), rate 3 -> 16, one non-last symbol -> underrun
      for (int a = 0; a < 16; a++) tbl_write(a, prev(a, 1));
      push_sym(3, 0, 0);
      pulse_start(2'd3);
      wait_idle();
      check(und_cnt == 2, "R7 underrun after symbol", 32'(und_cnt), 2);

      // Frame E: rate 16, single last symbol loaded during the preamble
      fork
         pulse_start(2'd2);
         begin
            repeat (100) @(negedge clk);
            push_sym(4, 0, 1);
         end
      join
      wait_idle();
      check(end_cnt == 3 && und_cnt == 2, "R6 frame E end", 32'(end_cnt), 3);

      chk_en = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule